// File: doc/BRIEF.md
# PDCCH Search Space Candidate Generator

This block lists, for one subframe, every downlink control candidate that a terminal has to try to decode. A start pulse latches a 16-bit terminal identifier, the slot number and the number of control channel elements (CCEs) in the control region. The block first runs a modular hashing recursion once per subframe up to the subframe index, which is the slot number halved. It then walks a fixed list of aggregation levels and emits the first CCE index of each candidate, one per clock. Each candidate carries its aggregation level code and a tag that says whether it belongs to the terminal-specific or the common space.

The terminal-specific space is hashed from the identifier. The common space always uses a hash value of zero. The two spaces may land on the same CCEs, and the block makes no attempt to remove duplicates. Downstream logic fetches the L CCEs that start at each emitted index and decodes them. A one-cycle done flag closes the list.

The controller is a state machine with six states:
- `ST_IDLE` waits for `start`.
- `ST_HASH` applies one multiply-and-reduce step per clock until the subframe index is reached.
- `ST_LEVEL` loads the next entry of the level list and then does one of three things. If the quotient floor(N/L) is zero it skips the entry, staying in `ST_LEVEL` or going to `ST_DONE` after the last entry. Otherwise it starts the remainder unit and goes to `ST_REM`.
- `ST_REM` waits for the remainder of the hash by the quotient and then moves to `ST_EMIT`.
- `ST_EMIT` outputs one candidate per clock. After the last candidate of a level it returns to `ST_LEVEL`, or goes to `ST_DONE` after the final level.
- `ST_DONE` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `pdcch_cand_gen`

## Requirements
- R1: After reset, `cand_valid` and `done` are low and stay low until a `start` pulse is seen.
- R2: The hash starts from Y = identifier and is updated as Y = (39827·Y) mod 65537 exactly floor(slot/2)+1 times, which gives the value for subframe floor(slot/2).
- R3: Candidate m of a level with CCE count L is reported as `cand_cce` = L·((Y + m) mod floor(N/L)). Only the first CCE of the candidate is reported.
- R4: The terminal-specific space is emitted first with `cand_common` = 0. It has 6, 6, 2 and 2 candidates at L = 1, 2, 4 and 8, in that order of levels, using the hashed Y.
- R5: The common space follows with `cand_common` = 1. It has 4 candidates at L = 4 and then 2 at L = 8, computed with Y = 0. No terminal-specific candidate appears after a common one.
- R6: When floor(N/L) is zero, the block emits no candidate at that level and continues with the next level. With N = 0 the list is empty and only `done` appears.
- R7: `done` is high for exactly one cycle, after the last candidate, and never in the same cycle as `cand_valid`. A full list holds 22 candidates.
- R8: A `start` pulse that arrives while a list is being produced is ignored. Changes to the other inputs at that time are also ignored.
- R9: `cand_lvl` encodes L as 0→1, 1→2, 2→4 and 3→8. Every emitted `cand_cce` is a multiple of L and the candidate ends inside the control region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins one subframe's candidate list |
| rnti | input | 16 | Terminal identifier that seeds the hash |
| slot | input | SLOT_W | Slot number in the radio frame (0 to 19) |
| ncce | input | CCE_W | Number of CCEs in the control region |
| cand_valid | output | 1 | A candidate is presented this cycle |
| cand_cce | output | CCE_W | First CCE index of the candidate |
| cand_lvl | output | 2 | Aggregation level code (L = 2^code) |
| cand_common | output | 1 | 1 for the common space, 0 for the terminal-specific space |
| done | output | 1 | One-cycle end-of-list flag |

## Verification
The hardest cases to reach from the ports are levels whose quotient floor(N/L) is zero or one. In those cases whole levels are skipped, or every candidate collapses onto index 0 through the wrap of (Y+m) mod Q. The bench reaches them by sweeping very small CCE counts (0, 1, 3 and 5) together with larger ones, across all twenty slots and several identifiers. This drives the hash through every recursion depth and the wrap through every offset. Some runs also fire a second `start`, with changed inputs, in the middle of a list to confirm that it is ignored.

// File: rtl/pdcch_cand_pkg.sv
package pdcch_cand_pkg;

    localparam int ID_W     = 16;
    localparam int Y_W      = 17;
    localparam int LVL_N    = 6;
    localparam int LVL_IX_W = 3;
    localparam int MCNT_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HASH,
        ST_LEVEL,
        ST_REM,
        ST_EMIT,
        ST_DONE
    } gen_state_e;

    typedef struct packed {
        logic [1:0]        code;
        logic [MCNT_W-1:0] count;
        logic              common;
    } lvl_entry_t;

    // Emission order: terminal-specific L=1,2,4,8 then common L=4,8
    function automatic lvl_entry_t lvl_entry(input logic [LVL_IX_W-1:0] ix);
        lvl_entry_t e;
        unique case (ix)
            3'd0:    e = '{code: 2'd0, count: 3'd6, common: 1'b0};
            3'd1:    e = '{code: 2'd1, count: 3'd6, common: 1'b0};
            3'd2:    e = '{code: 2'd2, count: 3'd2, common: 1'b0};
            3'd3:    e = '{code: 2'd3, count: 3'd2, common: 1'b0};
            3'd4:    e = '{code: 2'd2, count: 3'd4, common: 1'b1};
            3'd5:    e = '{code: 2'd3, count: 3'd2, common: 1'b1};
            default: e = '{code: 2'd0, count: 3'd1, common: 1'b0};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pdcch_hash_step.sv
// One step of Y' = (MULT * Y) mod 65537, using 2^16 = -1 (mod 65537).
module pdcch_hash_step #(
    parameter int MULT = 39827
) (
    input  logic [16:0] y_in,
    output logic [16:0] y_out
);
    localparam logic [18:0] MODV = 19'd65537;

    logic [33:0] prod;
    logic [18:0] diff;

    always_comb begin
        prod = 34'(y_in) * 34'(MULT);
        diff = 19'(prod[15:0]) - 19'(prod[33:16]);
        if (diff[18]) begin
            diff = diff + MODV;
        end
        y_out = diff[16:0];
    end
endmodule

// File: rtl/pdcch_rem_unit.sv
// Restoring remainder: one dividend bit per clock, done pulses once.
module pdcch_rem_unit #(
    parameter int DVD_W = 17,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DIV_W-1:0] divisor,
    output logic             done,
    output logic [DIV_W-1:0] rem
);
    localparam int CNT_W = $clog2(DVD_W);

    logic [DVD_W-1:0] shreg_q;
    logic [DIV_W-1:0] rem_q, rem_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q, done_q;
    logic [DIV_W:0]   trial;

    always_comb begin
        trial = {rem_q, shreg_q[DVD_W-1]};
        if (trial >= {1'b0, divisor}) begin
            rem_nxt = DIV_W'(trial - {1'b0, divisor});
        end else begin
            rem_nxt = trial[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            rem_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else if (start) begin
            shreg_q <= dividend;
            rem_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
        end else if (busy_q) begin
            shreg_q <= shreg_q << 1;
            rem_q   <= rem_nxt;
            if (cnt_q == CNT_W'(DVD_W - 1)) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done = done_q;
    assign rem  = rem_q;
endmodule

// File: rtl/pdcch_cand_gen.sv
module pdcch_cand_gen
    import pdcch_cand_pkg::*;
#(
    parameter int CCE_W  = 8,
    parameter int SLOT_W = 5,
    parameter int MULT   = 39827
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ID_W-1:0]   rnti,
    input  logic [SLOT_W-1:0] slot,
    input  logic [CCE_W-1:0]  ncce,
    output logic              cand_valid,
    output logic [CCE_W-1:0]  cand_cce,
    output logic [1:0]        cand_lvl,
    output logic              cand_common,
    output logic              done
);
    localparam int K_W = SLOT_W - 1;

    gen_state_e state_q, state_d;

    logic [Y_W-1:0]      y_q, y_nxt;
    logic [K_W-1:0]      k_q, step_q;
    logic [CCE_W-1:0]    ncce_q;
    logic [LVL_IX_W-1:0] lvl_q;
    logic [MCNT_W-1:0]   m_q;
    logic [CCE_W-1:0]    idx_q;

    lvl_entry_t          cur;
    logic [CCE_W-1:0]    quot;
    logic                last_lvl, last_cand, div_start, div_done;
    logic [CCE_W-1:0]    div_rem;
    logic [Y_W-1:0]      div_arg;
    logic [CCE_W-1:0]    idx_inc;

    pdcch_hash_step #(.MULT(MULT)) u_hash (
        .y_in  (y_q),
        .y_out (y_nxt)
    );

    pdcch_rem_unit #(.DVD_W(Y_W), .DIV_W(CCE_W)) u_rem (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_arg),
        .divisor  (quot),
        .done     (div_done),
        .rem      (div_rem)
    );

    always_comb begin
        cur       = lvl_entry(lvl_q);
        quot      = ncce_q >> cur.code;
        last_lvl  = (lvl_q == LVL_IX_W'(LVL_N - 1));
        last_cand = (m_q == cur.count - 1'b1);
        div_arg   = cur.common ? '0 : y_q;
        div_start = (state_q == ST_LEVEL) && (quot != '0);
        idx_inc   = idx_q + 1'b1;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_HASH;
            ST_HASH:  if (step_q == k_q) state_d = ST_LEVEL;
            ST_LEVEL: begin
                if (quot != '0)    state_d = ST_REM;
                else if (last_lvl) state_d = ST_DONE;
            end
            ST_REM:   if (div_done) state_d = ST_EMIT;
            ST_EMIT: begin
                if (last_cand) state_d = last_lvl ? ST_DONE : ST_LEVEL;
            end
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q    <= '0;
            k_q    <= '0;
            step_q <= '0;
            ncce_q <= '0;
            lvl_q  <= '0;
            m_q    <= '0;
            idx_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    y_q    <= Y_W'(rnti);
                    k_q    <= slot[SLOT_W-1:1];
                    ncce_q <= ncce;
                    step_q <= '0;
                    lvl_q  <= '0;
                end
                ST_HASH: begin
                    y_q    <= y_nxt;
                    step_q <= step_q + 1'b1;
                end
                ST_LEVEL: if (quot == '0 && !last_lvl) lvl_q <= lvl_q + 1'b1;
                ST_REM: if (div_done) begin
                    idx_q <= div_rem;
                    m_q   <= '0;
                end
                ST_EMIT: begin
                    idx_q <= (idx_inc == quot) ? '0 : idx_inc;
                    m_q   <= m_q + 1'b1;
                    if (last_cand && !last_lvl) lvl_q <= lvl_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cand_valid  = (state_q == ST_EMIT);
        cand_cce    = idx_q << cur.code;
        cand_lvl    = cur.code;
        cand_common = cur.common;
        done        = (state_q == ST_DONE);
    end
endmodule

// File: rtl/pdcch_cand_chk.sv
module pdcch_cand_chk #(
    parameter int CCE_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cand_valid,
    input logic [CCE_W-1:0] cand_cce,
    input logic [1:0]       cand_lvl,
    input logic             cand_common,
    input logic             done,
    input logic [CCE_W-1:0] ncce_q
);
    p_in_region_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> ((32'(cand_cce) + (32'd1 << cand_lvl)) <= 32'(ncce_q)));

    p_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> ((32'(cand_cce) & ((32'd1 << cand_lvl) - 32'd1)) == 32'd0));

    p_common_levels_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_common) |-> (cand_lvl >= 2'd2));

    p_common_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_common) |=> !(cand_valid && !cand_common));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cand_valid);
endmodule

bind pdcch_cand_gen pdcch_cand_chk #(.CCE_W(CCE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cand_valid  (cand_valid),
    .cand_cce    (cand_cce),
    .cand_lvl    (cand_lvl),
    .cand_common (cand_common),
    .done        (done),
    .ncce_q      (ncce_q)
);

// File: tb/pdcch_cand_gen_tb.sv
module pdcch_cand_gen_tb;
    localparam int CCE_W  = 8;
    localparam int SLOT_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [15:0]       rnti = '0;
    logic [SLOT_W-1:0] slot = '0;
    logic [CCE_W-1:0]  ncce = '0;
    logic              cand_valid, cand_common, done;
    logic [CCE_W-1:0]  cand_cce;
    logic [1:0]        cand_lvl;

    int n_tests = 0;
    int n_fail  = 0;

    int exp_cce [32];
    int exp_lvl [32];
    int exp_com [32];
    int exp_n;

    always #4 clk = ~clk;

    pdcch_cand_gen #(.CCE_W(CCE_W), .SLOT_W(SLOT_W)) u_dut (
        .clk, .rst_n, .start, .rnti, .slot, .ncce,
        .cand_valid, .cand_cce, .cand_lvl, .cand_common, .done
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic void build(input int id, input int sl, input int n);
        longint y;
        int codes [6] = '{0, 1, 2, 3, 2, 3};
        int cnts  [6] = '{6, 6, 2, 2, 4, 2};
        int coms  [6] = '{0, 0, 0, 0, 1, 1};
        y = id;
        for (int s = 0; s <= sl / 2; s++) y = (y * 39827) % 65537;
        exp_n = 0;
        for (int e = 0; e < 6; e++) begin
            int q;
            longint yy;
            q = n >> codes[e];
            if (q == 0) continue;
            yy = coms[e] ? 0 : y;
            for (int m = 0; m < cnts[e]; m++) begin
                exp_cce[exp_n] = (1 << codes[e]) * int'((yy + m) % q);
                exp_lvl[exp_n] = codes[e];
                exp_com[exp_n] = coms[e];
                exp_n++;
            end
        end
    endfunction

    task automatic run(input int id, input int sl, input int n, input bit disturb);
        int got;
        int cyc;
        bit fin;
        build(id, sl, n);
        @(negedge clk);
        rnti = 16'(id); slot = SLOT_W'(sl); ncce = CCE_W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 0; cyc = 0; fin = 0;
        while (!fin && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (disturb && cyc == 5) begin
                start = 1'b1; rnti = ~rnti; slot = SLOT_W'((sl + 3) % 20); ncce = ncce + 8'd7;
            end else if (disturb && cyc == 6) begin
                start = 1'b0;
            end
            if (cand_valid) begin
                if (got < exp_n) begin
                    check(int'(cand_cce) == exp_cce[got], disturb ? "R8 cce" : "R3 cce (hash R2)",
                          int'(cand_cce), exp_cce[got]);
                    check(int'(cand_lvl) == exp_lvl[got], "R4/R9 level", int'(cand_lvl), exp_lvl[got]);
                    check(int'(cand_common) == exp_com[got], "R5 space tag", int'(cand_common), exp_com[got]);
                end
                got++;
            end
            if (done) fin = 1;
        end
        if (!fin) check(0, "watchdog R7", cyc, 0);
        check(got == exp_n, (n < 8) ? "R6 count" : "R7 count", got, exp_n);
        @(negedge clk);
        check(!done && !cand_valid, "R7 done one cycle", int'(done), 0);
    endtask

    initial begin
        int ids [3] = '{16'h1234, 16'hFFFF, 16'h00A5};
        int ns  [8] = '{0, 1, 3, 5, 9, 17, 42, 88};
        repeat (3) @(negedge clk);
        check(!cand_valid && !done, "R1 in reset", int'(cand_valid), 0);
        rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(!cand_valid && !done, "R1 idle after reset", int'(cand_valid) + int'(done), 0);
        end
        for (int a = 0; a < 3; a++)
            for (int s = 0; s < 20; s++)
                for (int c = 0; c < 8; c++)
                    run(ids[a], s, ns[c], (s % 7 == 3));
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule